// File: doc/BRIEF.md
# MAC Address Table with Aging

This block is the address memory of a small two-port Ethernet switch that also has a host port. It keeps a direct-mapped table of 48-bit station addresses. Each slot holds a port map and a set of flags: valid, age/override, static, filter and a 2-bit priority. Each incoming frame is presented as one lookup request that carries its destination address, its source address and its ingress port. In the same cycle the block reads the destination slot to make a forwarding decision and updates the source slot, refreshing an existing entry or creating a new one.

The host can also install or remove entries. It stages an entry in two 32-bit words and then issues a make-entry command. A background sweep runs once per programmable interval and removes dynamic entries that have seen no traffic. An idle dynamic entry therefore disappears after one to two intervals. Static entries are never learned over and never aged.

All table writers share one write port. A lookup always takes the table. A pending host commit takes the next cycle with no lookup, and the sweep advances only in cycles that neither of the other two uses.

Top module: `mac_age_table`

## Requirements
- R1: An address maps to slot `mac[3:0] XOR mac[7:4]` (for the default 16 slots). A lookup hits only when that slot is valid and holds the same 48-bit address. The result appears on `res_*` in the cycle after `lu_valid_i`, with `res_valid_o` high for exactly that cycle. Every `res_*` field is zero when `res_valid_o` is low.
- R2: On a miss, `res_hit_o` is 0 and `res_ports_o` floods to every port except the ingress port. Port p is bit p of the port map.
- R3: On a hit that is not filtered, `res_ports_o` is the entry's port map with the ingress port bit cleared.
- R4: On a hit on an entry with the filter flag set, `res_drop_o` is 1 and `res_ports_o` is 0.
- R5: `res_override_o` is 1 only on a hit on an entry that has both the static flag and the age/override flag set.
- R6: `res_prio_vld_o` is 1 only on a hit on a static entry while `prio_en_i` was high in the lookup cycle. In that case `res_prio_o` carries the entry's priority; otherwise `res_prio_o` is 0.
- R7: Learning works on the source address of every lookup. A match on a dynamic entry sets its age flag and moves its port map to the ingress port. A non-matching slot that is not a valid static entry is overwritten with a new dynamic entry: valid and age set, filter clear, priority 0, port map set to the ingress port.
- R8: Learning never modifies a static entry, whether the source address matches it or only maps to its slot.
- R9: The low staging word holds address bits 31:0. In the high staging word, bits 15:0 hold address bits 47:32, bits 18:16 the port map, bits 20:19 the priority, bit 21 filter, bit 22 static, bit 23 age/override and bit 24 valid; bits 31:25 are ignored. A commit with valid set writes the staged entry into its slot.
- R10: A commit with the valid bit clear empties the slot only if that slot holds the same address. Otherwise the table is unchanged.
- R11: A sweep starts after every TICK_CYCLES*INTERVAL_TICKS clocks. It visits slots 0 to DEPTH-1, one slot per cycle in which there is no lookup and no pending commit. At each valid dynamic slot it clears a set age flag, or empties the slot if the age flag was already clear. Static slots are left alone.
- R12: `host_busy_o` rises in the cycle after a make-entry pulse and stays high while lookups occupy the table. It falls after the first cycle without a lookup, in which the commit happens. A make-entry pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lu_valid_i | input | 1 | Lookup/learn request this cycle |
| lu_da_i | input | 48 | Destination address to look up |
| lu_sa_i | input | 48 | Source address to learn |
| lu_port_i | input | 2 | Ingress port number (0..2) |
| prio_en_i | input | 1 | Global enable for per-entry priority |
| host_wdata_i | input | 32 | Staging write data |
| host_wr_lo_i | input | 1 | Write low staging word |
| host_wr_hi_i | input | 1 | Write high staging word |
| host_make_i | input | 1 | Make-entry command pulse |
| host_busy_o | output | 1 | Commit pending |
| res_valid_o | output | 1 | Lookup result valid |
| res_hit_o | output | 1 | Destination matched a valid entry |
| res_ports_o | output | 3 | Egress port map |
| res_drop_o | output | 1 | Frame filtered |
| res_override_o | output | 1 | Forward regardless of port state |
| res_prio_vld_o | output | 1 | Entry priority applies |
| res_prio_o | output | 2 | Entry priority |

## Verification
The properties assume that `lu_port_i` always names an existing port (below 3). Under that assumption the ingress bit of the flood map is always defined. They also assume that the staging words are not rewritten while `host_busy_o` is high, so the committed entry is the one that was staged before the command. The stimulus only drives port numbers 0 to 2. It writes both staging words before each make-entry pulse and then idles or issues lookups until busy falls. The only make-entry pulse it gives during a busy window is the one meant to be ignored.

// File: rtl/mat_pkg.sv
package mat_pkg;
  localparam int MAC_W      = 48;
  localparam int NUM_PORTS  = 3;
  localparam int PORT_IDX_W = $clog2(NUM_PORTS);

  // high staging word layout
  localparam int HI_PORT_LSB = 16;
  localparam int HI_PRIO_LSB = 19;
  localparam int HI_FILTER   = 21;
  localparam int HI_STATIC   = 22;
  localparam int HI_AGE      = 23;
  localparam int HI_VALID    = 24;

  typedef logic [NUM_PORTS-1:0] port_map_t;

  typedef struct packed {
    logic             valid;
    logic             age;
    logic             is_static;
    logic             filter;
    logic [1:0]       prio;
    port_map_t        ports;
    logic [MAC_W-1:0] mac;
  } entry_t;

  typedef struct packed {
    logic       valid;
    logic       hit;
    logic       drop;
    logic       override;
    logic       prio_vld;
    logic [1:0] prio;
    port_map_t  ports;
  } result_t;

  function automatic port_map_t port_bit(input logic [PORT_IDX_W-1:0] p);
    return port_map_t'(1) << p;
  endfunction
endpackage

// File: rtl/mat_age_timer.sv
module mat_age_timer #(
  parameter int TICK_CYCLES    = 4,
  parameter int INTERVAL_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sweep_start_o
);
  localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int INTV_W = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;

  logic [TICK_W-1:0] tick_q;
  logic [INTV_W-1:0] intv_q;
  logic              tick_end, intv_end;

  assign tick_end = (tick_q == TICK_W'(TICK_CYCLES - 1));
  assign intv_end = (intv_q == INTV_W'(INTERVAL_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      intv_q <= '0;
    end else begin
      tick_q <= tick_end ? '0 : tick_q + 1'b1;
      if (tick_end) intv_q <= intv_end ? '0 : intv_q + 1'b1;
    end
  end

  assign sweep_start_o = tick_end & intv_end;
endmodule

// File: rtl/mat_host_stage.sv
module mat_host_stage
  import mat_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] wdata_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic        make_i,
  input  logic        commit_i,
  output entry_t      staged_o,
  output logic        pend_o
);
  logic [31:0] lo_q;
  logic [24:0] hi_q;
  logic        pend_q;
  logic        unused_hi;

  assign unused_hi = ^wdata_i[31:25];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_lo_i) lo_q <= wdata_i;
      if (wr_hi_i) hi_q <= wdata_i[24:0];
      pend_q <= (pend_q & ~commit_i) | (make_i & ~pend_q);
    end
  end

  always_comb begin
    staged_o.valid     = hi_q[HI_VALID];
    staged_o.age       = hi_q[HI_AGE];
    staged_o.is_static = hi_q[HI_STATIC];
    staged_o.filter    = hi_q[HI_FILTER];
    staged_o.prio      = hi_q[HI_PRIO_LSB +: 2];
    staged_o.ports     = hi_q[HI_PORT_LSB +: NUM_PORTS];
    staged_o.mac       = {hi_q[15:0], lo_q};
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/mat_decide.sv
module mat_decide
  import mat_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lu_valid_i,
  input  logic [MAC_W-1:0]      lu_da_i,
  input  logic [PORT_IDX_W-1:0] lu_port_i,
  input  logic                  prio_en_i,
  input  entry_t                rd_i,
  output result_t               res_o
);
  result_t   nxt, res_q;
  port_map_t others;

  always_comb begin
    others       = ~port_bit(lu_port_i);
    nxt          = '0;
    nxt.valid    = 1'b1;
    nxt.hit      = rd_i.valid && (rd_i.mac == lu_da_i);
    nxt.drop     = nxt.hit && rd_i.filter;
    nxt.override = nxt.hit && rd_i.is_static && rd_i.age;
    nxt.prio_vld = nxt.hit && rd_i.is_static && prio_en_i;
    nxt.prio     = nxt.prio_vld ? rd_i.prio : 2'b00;
    if (nxt.drop)     nxt.ports = '0;
    else if (nxt.hit) nxt.ports = rd_i.ports & others;
    else              nxt.ports = others;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= lu_valid_i ? nxt : '0;
  end

  assign res_o = res_q;
endmodule

// File: rtl/mac_age_table.sv
module mac_age_table
  import mat_pkg::*;
#(
  parameter int DEPTH          = 16,
  parameter int TICK_CYCLES    = 25_000_000,
  parameter int INTERVAL_TICKS = 300
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lu_valid_i,
  input  logic [MAC_W-1:0]      lu_da_i,
  input  logic [MAC_W-1:0]      lu_sa_i,
  input  logic [PORT_IDX_W-1:0] lu_port_i,
  input  logic                  prio_en_i,
  input  logic [31:0]           host_wdata_i,
  input  logic                  host_wr_lo_i,
  input  logic                  host_wr_hi_i,
  input  logic                  host_make_i,
  output logic                  host_busy_o,
  output logic                  res_valid_o,
  output logic                  res_hit_o,
  output logic [NUM_PORTS-1:0]  res_ports_o,
  output logic                  res_drop_o,
  output logic                  res_override_o,
  output logic                  res_prio_vld_o,
  output logic [1:0]            res_prio_o
);
  localparam int IDX_W = $clog2(DEPTH);

  function automatic logic [IDX_W-1:0] slot_of(input logic [MAC_W-1:0] m);
    return m[IDX_W-1:0] ^ m[2*IDX_W-1:IDX_W];
  endfunction

  entry_t            tbl [DEPTH];
  entry_t            staged, sa_e, cm_e, sw_e, learn_e, wr_e;
  logic [IDX_W-1:0]  da_idx, sa_idx, stg_idx, wr_idx, sweep_idx_q;
  logic              pend, commit, sweep_on_q, sweep_step, sweep_start;
  logic              learn_we, wr_en;
  result_t           res;

  mat_age_timer #(
    .TICK_CYCLES   (TICK_CYCLES),
    .INTERVAL_TICKS(INTERVAL_TICKS)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sweep_start_o(sweep_start)
  );

  mat_host_stage u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wdata_i (host_wdata_i),
    .wr_lo_i (host_wr_lo_i),
    .wr_hi_i (host_wr_hi_i),
    .make_i  (host_make_i),
    .commit_i(commit),
    .staged_o(staged),
    .pend_o  (pend)
  );

  assign da_idx  = slot_of(lu_da_i);
  assign sa_idx  = slot_of(lu_sa_i);
  assign stg_idx = slot_of(staged.mac);
  assign sa_e    = tbl[sa_idx];
  assign cm_e    = tbl[stg_idx];
  assign sw_e    = tbl[sweep_idx_q];

  // lookups own the write port; commit next; sweep last
  assign commit     = pend & ~lu_valid_i;
  assign sweep_step = sweep_on_q & ~lu_valid_i & ~pend;

  always_comb begin
    learn_we = 1'b0;
    learn_e  = sa_e;
    if (sa_e.valid && (sa_e.mac == lu_sa_i)) begin
      if (!sa_e.is_static) begin
        learn_we      = 1'b1;
        learn_e.age   = 1'b1;
        learn_e.ports = port_bit(lu_port_i);
      end
    end else if (!(sa_e.valid && sa_e.is_static)) begin
      learn_we      = 1'b1;
      learn_e       = '0;
      learn_e.valid = 1'b1;
      learn_e.age   = 1'b1;
      learn_e.ports = port_bit(lu_port_i);
      learn_e.mac   = lu_sa_i;
    end
  end

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = sa_idx;
    wr_e   = learn_e;
    if (lu_valid_i) begin
      wr_en = learn_we;
    end else if (pend) begin
      wr_idx = stg_idx;
      wr_e   = staged;
      if (staged.valid) begin
        wr_en = 1'b1;
      end else if (cm_e.valid && (cm_e.mac == staged.mac)) begin
        wr_en = 1'b1;
        wr_e  = '0;
      end
    end else if (sweep_on_q) begin
      wr_idx = sweep_idx_q;
      wr_e   = sw_e;
      if (sw_e.valid && !sw_e.is_static) begin
        wr_en = 1'b1;
        if (sw_e.age) wr_e.age = 1'b0;
        else          wr_e     = '0;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    entry_t slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                slot_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))    slot_q <= wr_e;
    end
    assign tbl[g] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sweep_on_q  <= 1'b0;
      sweep_idx_q <= '0;
    end else if (sweep_start && !sweep_on_q) begin
      sweep_on_q  <= 1'b1;
      sweep_idx_q <= '0;
    end else if (sweep_step) begin
      if (sweep_idx_q == IDX_W'(DEPTH - 1)) sweep_on_q <= 1'b0;
      sweep_idx_q <= sweep_idx_q + 1'b1;
    end
  end

  mat_decide u_decide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lu_valid_i(lu_valid_i),
    .lu_da_i   (lu_da_i),
    .lu_port_i (lu_port_i),
    .prio_en_i (prio_en_i),
    .rd_i      (tbl[da_idx]),
    .res_o     (res)
  );

  assign host_busy_o    = pend;
  assign res_valid_o    = res.valid;
  assign res_hit_o      = res.hit;
  assign res_ports_o    = res.ports;
  assign res_drop_o     = res.drop;
  assign res_override_o = res.override;
  assign res_prio_vld_o = res.prio_vld;
  assign res_prio_o     = res.prio;
endmodule

// File: rtl/mat_chk.sv
module mat_chk
  import mat_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  lu_valid_i,
  input logic [PORT_IDX_W-1:0] lu_port_i,
  input logic                  prio_en_i,
  input logic                  host_make_i,
  input logic                  host_busy_o,
  input logic                  res_valid_o,
  input logic                  res_hit_o,
  input logic [NUM_PORTS-1:0]  res_ports_o,
  input logic                  res_drop_o,
  input logic                  res_override_o,
  input logic                  res_prio_vld_o
);
  // R1
  res_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lu_valid_i |=> res_valid_o);
  // R1
  res_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lu_valid_i |=> !res_valid_o);
  // R2
  miss_flood_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_ports_o == ~port_bit($past(lu_port_i))));
  // R3
  no_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ((res_ports_o & port_bit($past(lu_port_i))) == '0));
  // R4
  drop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_drop_o) |-> (res_ports_o == '0) && res_hit_o);
  // R5
  override_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_override_o |-> res_hit_o);
  // R6
  prio_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_prio_vld_o |-> res_hit_o && $past(prio_en_i));
  // R12
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_make_i && !host_busy_o) |=> host_busy_o);
  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_busy_o && lu_valid_i) |=> host_busy_o);
endmodule

bind mac_age_table mat_chk u_mat_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lu_valid_i    (lu_valid_i),
  .lu_port_i     (lu_port_i),
  .prio_en_i     (prio_en_i),
  .host_make_i   (host_make_i),
  .host_busy_o   (host_busy_o),
  .res_valid_o   (res_valid_o),
  .res_hit_o     (res_hit_o),
  .res_ports_o   (res_ports_o),
  .res_drop_o    (res_drop_o),
  .res_override_o(res_override_o),
  .res_prio_vld_o(res_prio_vld_o)
);

// File: tb/mac_age_table_tb_top.sv
module mac_age_table_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int TICK  = 4;
  localparam int INTV  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lu_valid = 1'b0;
  logic [47:0] lu_da = '0, lu_sa = '0;
  logic [1:0]  lu_port = '0;
  logic        prio_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0, make = 1'b0;
  logic        busy, r_valid, r_hit, r_drop, r_ovr, r_pv;
  logic [2:0]  r_ports;
  logic [1:0]  r_prio;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model state
  bit          m_valid[DEPTH], m_age[DEPTH], m_static[DEPTH], m_filter[DEPTH];
  logic [1:0]  m_prio[DEPTH];
  logic [2:0]  m_ports[DEPTH];
  logic [47:0] m_mac[DEPTH];
  bit          m_pend = 0, m_sw_on = 0;
  int          m_sw_idx = 0, m_cyc = 0;
  logic [31:0] m_lo = '0, m_hi = '0;
  bit          e_busy, e_rv, e_hit, e_drop, e_ovr, e_pv;
  logic [2:0]  e_ports;
  logic [1:0]  e_prio;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_age_table #(.DEPTH(DEPTH), .TICK_CYCLES(TICK), .INTERVAL_TICKS(INTV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lu_valid_i(lu_valid), .lu_da_i(lu_da), .lu_sa_i(lu_sa),
    .lu_port_i(lu_port), .prio_en_i(prio_en), .host_wdata_i(wdata), .host_wr_lo_i(wr_lo),
    .host_wr_hi_i(wr_hi), .host_make_i(make), .host_busy_o(busy), .res_valid_o(r_valid),
    .res_hit_o(r_hit), .res_ports_o(r_ports), .res_drop_o(r_drop), .res_override_o(r_ovr),
    .res_prio_vld_o(r_pv), .res_prio_o(r_prio));

  function automatic int slot(input logic [47:0] m);
    return int'(m[3:0] ^ m[7:4]);
  endfunction

  function automatic logic [31:0] mk_hi(input bit v, input bit a, input bit s, input bit f,
                                        input logic [1:0] p, input logic [2:0] pm,
                                        input logic [15:0] mh);
    return {7'h55, v, a, s, f, p, pm, mh};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_slot(input int i);
    m_valid[i] = 0; m_age[i] = 0; m_static[i] = 0; m_filter[i] = 0;
    m_prio[i] = '0; m_ports[i] = '0; m_mac[i] = '0;
  endtask

  // advance one clock: model the edge from current inputs, then compare
  task automatic step(input string tag);
    bit pend0, on0, start, commit, sw, h;
    int di, si, ci;
    logic [2:0] others;
    logic [47:0] smac;
    pend0  = m_pend;
    on0    = m_sw_on;
    start  = (m_cyc % (TICK*INTV)) == TICK*INTV - 1;
    commit = pend0 && !lu_valid;
    sw     = on0 && !lu_valid && !pend0;
    e_rv = 0; e_hit = 0; e_drop = 0; e_ovr = 0; e_pv = 0; e_prio = '0; e_ports = '0;
    if (lu_valid) begin
      di = slot(lu_da);
      others = ~(3'b001 << lu_port);
      h = m_valid[di] && (m_mac[di] == lu_da);
      e_rv = 1; e_hit = h;
      e_drop = h && m_filter[di];
      e_ovr  = h && m_static[di] && m_age[di];
      e_pv   = h && m_static[di] && prio_en;
      e_prio = e_pv ? m_prio[di] : 2'b00;
      e_ports = e_drop ? 3'b000 : (h ? (m_ports[di] & others) : others);
      si = slot(lu_sa);
      if (m_valid[si] && m_mac[si] == lu_sa) begin
        if (!m_static[si]) begin m_age[si] = 1; m_ports[si] = 3'b001 << lu_port; end
      end else if (!(m_valid[si] && m_static[si])) begin
        clear_slot(si);
        m_valid[si] = 1; m_age[si] = 1; m_ports[si] = 3'b001 << lu_port; m_mac[si] = lu_sa;
      end
    end
    if (commit) begin
      smac = {m_hi[15:0], m_lo};
      ci = slot(smac);
      if (m_hi[24]) begin
        m_valid[ci] = 1; m_age[ci] = m_hi[23]; m_static[ci] = m_hi[22];
        m_filter[ci] = m_hi[21]; m_prio[ci] = m_hi[20:19]; m_ports[ci] = m_hi[18:16];
        m_mac[ci] = smac;
      end else if (m_valid[ci] && m_mac[ci] == smac) clear_slot(ci);
    end else if (sw) begin
      if (m_valid[m_sw_idx] && !m_static[m_sw_idx]) begin
        if (m_age[m_sw_idx]) m_age[m_sw_idx] = 0;
        else clear_slot(m_sw_idx);
      end
    end
    if (start && !on0) begin
      m_sw_on = 1; m_sw_idx = 0;
    end else if (sw) begin
      if (m_sw_idx == DEPTH-1) m_sw_on = 0;
      m_sw_idx = (m_sw_idx + 1) % DEPTH;
    end
    m_pend = (pend0 && !commit) || (make && !pend0);
    if (wr_lo) m_lo = wdata;
    if (wr_hi) m_hi = wdata;
    m_cyc++;
    e_busy = m_pend;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "busy", busy, e_busy);
    chk(tag, "res_valid", r_valid, e_rv);
    chk(tag, "result", {r_hit, r_drop, r_ovr, r_pv, r_prio, r_ports},
        {e_hit, e_drop, e_ovr, e_pv, e_prio, e_ports});
    lu_valid = 0; wr_lo = 0; wr_hi = 0; make = 0;
  endtask

  task automatic lookup(input logic [47:0] da, input logic [47:0] sa, input logic [1:0] p,
                        input string tag);
    lu_valid = 1; lu_da = da; lu_sa = sa; lu_port = p;
    step(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic stage(input logic [47:0] mac, input logic [31:0] hi, input string tag);
    wdata = mac[31:0]; wr_lo = 1; step(tag);
    wdata = hi;        wr_hi = 1; step(tag);
  endtask

  task automatic host_entry(input logic [47:0] mac, input logic [31:0] hi, input string tag);
    stage(mac, hi, tag);
    make = 1; step(tag);
    for (int i = 0; i < 8 && e_busy; i++) step(tag);
  endtask

  localparam logic [47:0] MAC_A = 48'h0000_1111_2201;  // slot 1
  localparam logic [47:0] MAC_B = 48'h0A0B_0C0D_0E12;  // slot 3
  localparam logic [47:0] MAC_X = 48'hFFFF_0C0D_0E12;  // slot 3, other address
  localparam logic [47:0] MAC_C = 48'h1234_5678_9A46;  // slot 2
  localparam logic [47:0] MAC_D = 48'h0000_0000_0077;  // slot 0
  localparam logic [47:0] MAC_E = 48'h0000_0000_00A5;  // slot 15
  localparam logic [47:0] MAC_F = 48'h0000_0000_00D6;  // slot 11
  localparam logic [47:0] MAC_U = 48'hDEAD_BEEF_0055;  // slot 0, never learned first
  localparam logic [47:0] MAC_N = 48'h0000_0000_0033;  // slot 0, source filler

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) clear_slot(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R12 reset state
    chk("R12", "busy after reset", busy, 1'b0);
    chk("R1", "outputs after reset", {r_valid, r_hit, r_ports, r_drop, r_ovr, r_pv, r_prio}, '0);

    // R2 miss floods to the other ports; learning creates MAC_N's entry
    lookup(MAC_U, MAC_N, 2'd0, "R2");
    chk("R2", "flood map", {r_hit, r_ports}, {1'b0, 3'b110});

    // R7 learn A on port 1, then R3 hit from port 0 and from port 1
    lookup(MAC_U, MAC_A, 2'd1, "R7");
    lookup(MAC_A, MAC_N, 2'd0, "R3");
    chk("R3", "learned forward", {r_hit, r_ports}, {1'b1, 3'b010});
    lookup(MAC_A, MAC_N, 2'd1, "R3");
    chk("R3", "ingress excluded", {r_hit, r_ports}, {1'b1, 3'b000});
    // R7 station moves to port 2
    lookup(MAC_U, MAC_A, 2'd2, "R7");
    lookup(MAC_A, MAC_N, 2'd0, "R7");
    chk("R7", "moved station", r_ports, 3'b100);

    // R9 static entry with override and priority
    host_entry(MAC_B, mk_hi(1, 1, 1, 0, 2'd2, 3'b101, MAC_B[47:32]), "R9");
    chk("R9", "busy cleared", busy, 1'b0);
    lookup(MAC_B, MAC_N, 2'd1, "R9");
    chk("R9", "static map", r_ports, 3'b101);
    chk("R5", "override", r_ovr, 1'b1);
    chk("R6", "prio gated off", {r_pv, r_prio}, 3'b000);
    prio_en = 1;
    lookup(MAC_B, MAC_N, 2'd0, "R6");
    chk("R6", "prio applied", {r_pv, r_prio}, {1'b1, 2'd2});
    lookup(MAC_A, MAC_N, 2'd0, "R6");
    chk("R6", "dynamic no prio", {r_pv, r_ovr}, 2'b00);

    // R8 learning never touches static B, by match or by slot collision
    lookup(MAC_U, MAC_B, 2'd1, "R8");
    lookup(MAC_U, MAC_X, 2'd2, "R8");
    lookup(MAC_B, MAC_N, 2'd1, "R8");
    chk("R8", "static kept", {r_hit, r_ports}, {1'b1, 3'b101});

    // R4 filter entry
    host_entry(MAC_C, mk_hi(1, 0, 1, 1, 2'd0, 3'b011, MAC_C[47:32]), "R4");
    lookup(MAC_C, MAC_N, 2'd2, "R4");
    chk("R4", "dropped", {r_hit, r_drop, r_ports}, {1'b1, 1'b1, 3'b000});

    // R10 invalidate with wrong address: no effect; with right address: removed
    host_entry(MAC_X, mk_hi(0, 0, 0, 0, 2'd0, 3'b000, MAC_X[47:32]), "R10");
    lookup(MAC_B, MAC_N, 2'd0, "R10");
    chk("R10", "other address kept", r_hit, 1'b1);
    host_entry(MAC_C, mk_hi(0, 0, 0, 0, 2'd0, 3'b000, MAC_C[47:32]), "R10");
    lookup(MAC_C, MAC_N, 2'd0, "R10");
    chk("R10", "entry removed", {r_hit, r_ports}, {1'b0, 3'b110});

    // R12 lookups hold off the commit; second make while busy ignored
    stage(MAC_F, mk_hi(1, 0, 1, 0, 2'd1, 3'b001, MAC_F[47:32]), "R12");
    make = 1;
    lookup(MAC_U, MAC_N, 2'd0, "R12");
    make = 1;
    lookup(MAC_U, MAC_N, 2'd0, "R12");
    lookup(MAC_F, MAC_N, 2'd1, "R12");
    chk("R12", "busy held", busy, 1'b1);
    chk("R12", "not yet committed", r_hit, 1'b0);
    step("R12");
    chk("R12", "busy released", busy, 1'b0);
    step("R12");
    chk("R12", "extra make ignored", busy, 1'b0);
    lookup(MAC_F, MAC_N, 2'd1, "R12");
    chk("R12", "committed", {r_hit, r_ports}, {1'b1, 3'b001});

    // R11 idle dynamic entry ages out; refreshed entry and static entry survive
    lookup(MAC_U, MAC_D, 2'd2, "R11");
    for (int k = 0; k < 6; k++) begin
      lookup(MAC_U, MAC_E, 2'd1, "R11");
      idle(20, "R11");
    end
    lookup(MAC_D, MAC_N, 2'd1, "R11");
    chk("R11", "idle entry aged out", r_hit, 1'b0);
    lookup(MAC_E, MAC_F, 2'd0, "R11");
    chk("R11", "refreshed entry kept", {r_hit, r_ports}, {1'b1, 3'b010});
    lookup(MAC_B, MAC_F, 2'd0, "R11");
    chk("R11", "static survives aging", {r_hit, r_ports}, {1'b1, 3'b100});
    idle(100, "R11");
    lookup(MAC_A, MAC_F, 2'd0, "R11");
    chk("R11", "old dynamic removed", r_hit, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule